// File: doc/BRIEF.md
# Comparator Control and Event Logic

This block is the digital wrapper that sits beside an analog voltage comparator. Software configures it through a single 32-bit control word on a simple synchronous register port. The port has an already-decoded write strobe, a full-word write and combinational read data. The block takes the comparator's raw decision as a digital input and passes it through a two-flop synchronizer. It can invert the result, and it reports the conditioned level as a read-only status bit. It can drive that level onto an output pin, and it raises a one-clock interrupt pulse on a chosen edge of the conditioned level.

The inversion is applied before the edge detector. Flipping the inversion bit therefore moves the interrupt to the opposite physical edge of the raw comparator signal. Two outputs tell the analog side which inputs to connect: a 1-bit positive-input select and a 2-bit negative-input select. While the block is disabled, the status and pin levels stay low and no interrupt is raised. The edge history keeps following the input, so enabling the block again with the comparator already high gives no spurious pulse.

Top module: `anacmp_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_00C3. Enable (bit 15), pin-drive enable (bit 14), invert (bit 13), status (bit 8) and positive select (bit 4) are 0. Edge mode (bits 7:6) is 11 and negative select (bits 1:0) is 11.
- R2: A write with `regWe` high stores bits 15, 14, 13, 7:6, 4 and 1:0 of `regWdata`. Bits 31:16, 12:9, 5 and 3:2 always read 0. Bit 8 ignores writes.
- R3: Read bit 8 equals (synchronized `cmpRaw`) XOR invert while enabled, and 0 while disabled. A change on `cmpRaw` reaches bit 8 after two rising clock edges.
- R4: Edge mode 00 produces no interrupt on any input change.
- R5: Edge mode 01 pulses `irqPulse` on a 0-to-1 change of the conditioned level and mode 10 on a 1-to-0 change. Mode 11 pulses on both. Each pulse lasts one clock and appears on the third rising edge after `cmpRaw` changes.
- R6: With invert set, a given edge mode fires on the opposite edge of `cmpRaw`.
- R7: While disabled, no interrupt is raised for any input change. Enabling with the conditioned level already high raises no pulse.
- R8: `pinOe` equals bit 14. `pinOut` equals the status level while bit 14 is 1, and 0 otherwise.
- R9: `posSel` follows bit 4 (1 = internal reference, 0 = external pin). `negSel` follows bits 1:0 (00, 01, 10 = first, second, third pin; 11 = internal reference).
- R10: Changing only the enable bit in a write leaves all other stored fields as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Decoded write strobe for the control word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| cmpRaw | input | 1 | Raw comparator decision |
| pinOut | output | 1 | Level for the output pin |
| pinOe | output | 1 | Output pin drive enable |
| irqPulse | output | 1 | One-clock interrupt pulse |
| posSel | output | 1 | Positive-input select to analog side |
| negSel | output | 2 | Negative-input select to analog side |

## Verification
On every cycle, the assertions check the following. No pulse appears after a disabled cycle or under edge mode 00. A pulse under the rise-only or fall-only mode follows the matching conditioned level. The stored fields hold when there is no write. The pin stays quiet without drive enable. Only the directed scenarios show the exact three-edge pulse latency and the swap of physical edge under inversion. The same holds for the absence of a pulse on re-enable, the reset word and the masking of unimplemented and read-only bits.

// File: rtl/anacmp_pkg.sv
package anacmp_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned B_RUN    = 15;
  localparam int unsigned B_DRV    = 14;
  localparam int unsigned B_INV    = 13;
  localparam int unsigned B_LIVE   = 8;
  localparam int unsigned B_EDGE_H = 7;
  localparam int unsigned B_EDGE_L = 6;
  localparam int unsigned B_POS    = 4;
  localparam int unsigned B_NEG_H  = 1;
  localparam int unsigned B_NEG_L  = 0;

  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  typedef struct packed {
    logic       runEn;
    logic       pinDrvEn;
    logic       invert;
    logic [1:0] edgeMode;
  } cmpStrobe_t;
endpackage

// File: rtl/anacmp_regs.sv
module anacmp_regs
  import anacmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  input  logic             liveOut,
  output logic [REG_W-1:0] regRdata,
  output cmpStrobe_t       stb,
  output logic             posSel,
  output logic [1:0]       negSel
);
  logic       runEn, drvEn, invEn, posQ;
  logic [1:0] edgeQ, negQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn <= 1'b0;
      drvEn <= 1'b0;
      invEn <= 1'b0;
      edgeQ <= EDGE_BOTH;
      posQ  <= 1'b0;
      negQ  <= 2'b11;
    end else if (regWe) begin
      runEn <= regWdata[B_RUN];
      drvEn <= regWdata[B_DRV];
      invEn <= regWdata[B_INV];
      edgeQ <= regWdata[B_EDGE_H:B_EDGE_L];
      posQ  <= regWdata[B_POS];
      negQ  <= regWdata[B_NEG_H:B_NEG_L];
    end
  end

  always_comb begin
    regRdata                   = '0;
    regRdata[B_RUN]            = runEn;
    regRdata[B_DRV]            = drvEn;
    regRdata[B_INV]            = invEn;
    regRdata[B_LIVE]           = liveOut;
    regRdata[B_EDGE_H:B_EDGE_L] = edgeQ;
    regRdata[B_POS]            = posQ;
    regRdata[B_NEG_H:B_NEG_L]   = negQ;
  end

  assign stb.runEn    = runEn;
  assign stb.pinDrvEn = drvEn;
  assign stb.invert   = invEn;
  assign stb.edgeMode = edgeQ;
  assign posSel       = posQ;
  assign negSel       = negQ;

  // R2 / R10: fields only move on a write
  a_r10_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable({runEn, drvEn, invEn, edgeQ, posQ, negQ}));
endmodule

// File: rtl/anacmp_dp.sv
module anacmp_dp
  import anacmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpRaw,
  input  cmpStrobe_t stb,
  output logic       liveOut,
  output logic       pinOut,
  output logic       pinOe,
  output logic       irqPulse
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic condLvl, prevLvl, hit;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= cmpRaw;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], cmpRaw};
      end
    end
  endgenerate

  assign condLvl = syncQ[LAST] ^ stb.invert;

  always_comb begin
    unique case (stb.edgeMode)
      EDGE_RISE: hit = condLvl & ~prevLvl;
      EDGE_FALL: hit = ~condLvl & prevLvl;
      EDGE_BOTH: hit = condLvl ^ prevLvl;
      default:   hit = 1'b0;
    endcase
  end

  // history follows the level even while disabled, so re-enable sees no edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      prevLvl  <= condLvl;
      irqPulse <= stb.runEn & hit;
    end
  end

  assign liveOut = stb.runEn & condLvl;
  assign pinOe   = stb.pinDrvEn;
  assign pinOut  = stb.pinDrvEn & liveOut;

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.runEn) |-> !irqPulse);
  a_r4_mode_off: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.edgeMode) == EDGE_OFF) |-> !irqPulse);
  a_r5_rise_level: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && $past(stb.edgeMode) == EDGE_RISE) |-> $past(condLvl));
  a_r5_fall_level: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && $past(stb.edgeMode) == EDGE_FALL) |-> !$past(condLvl));
  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> !pinOut);
endmodule

// File: rtl/anacmp_ctrl.sv
module anacmp_ctrl
  import anacmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        cmpRaw,
  output logic        pinOut,
  output logic        pinOe,
  output logic        irqPulse,
  output logic        posSel,
  output logic [1:0]  negSel
);
  cmpStrobe_t stb;
  logic       liveOut;

  anacmp_regs u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .liveOut(liveOut), .regRdata(regRdata), .stb(stb),
    .posSel(posSel), .negSel(negSel)
  );

  anacmp_dp #(.SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .cmpRaw(cmpRaw), .stb(stb),
    .liveOut(liveOut), .pinOut(pinOut), .pinOe(pinOe), .irqPulse(irqPulse)
  );
endmodule

// File: tb/anacmp_ctrl_tb.sv
`timescale 1ns/1ps
module anacmp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        cmpRaw = 1'b0;
  logic        pinOut, pinOe, irqPulse, posSel;
  logic [1:0]  negSel;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  anacmp_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .cmpRaw(cmpRaw), .pinOut(pinOut), .pinOe(pinOe),
    .irqPulse(irqPulse), .posSel(posSel), .negSel(negSel)
  );

  localparam logic [31:0] RUN = 32'h8000, DRV = 32'h4000, INV = 32'h2000;
  localparam logic [31:0] M_OFF = 32'h00, M_RISE = 32'h40, M_FALL = 32'h80, M_BOTH = 32'hC0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regWdata = d;
    @(negedge clk); regWe = 1'b0; regWdata = '0;
  endtask

  task automatic settle(output int pulses);
    pulses = 0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      if (irqPulse) pulses++;
    end
  endtask

  // change raw, count pulses over 6 edges, require any pulse on edge 3
  task automatic rawStep(input string req, input logic v, input int expCnt);
    int cnt = 0;
    int at = 0;
    @(negedge clk); cmpRaw = v;
    for (int i = 1; i <= 6; i++) begin
      @(posedge clk); #1;
      if (irqPulse) begin cnt++; at = i; end
    end
    chk(req, cnt, expCnt);
    if (expCnt == 1) chk({req, " latency"}, at, 3);
  endtask

  task automatic tReset();
    #1;
    chk("R1 reset word", regRdata, 32'h0000_00C3);
    chk("R1 reset irq", irqPulse, 0);
    chk("R9 reset negSel", negSel, 2'b11);
  endtask

  task automatic tRegAccess();
    int p;
    wr(32'hFFFF_FFFF); settle(p);
    chk("R2 all ones", regRdata, 32'h0000_E1D3);
    wr(32'h0000_1F2C | 32'h100); settle(p);
    chk("R2 unimpl and ro ignored", regRdata, 32'h0);
  endtask

  task automatic tStatus();
    int p;
    wr(RUN | M_BOTH); settle(p);
    @(negedge clk); cmpRaw = 1'b1;
    @(posedge clk); #1;
    chk("R3 status after 1 edge", regRdata[8], 0);
    @(posedge clk); #1;
    chk("R3 status after 2 edges", regRdata[8], 1);
    settle(p);
    rawStep("R3 back low", 1'b0, 1);
    chk("R3 status low", regRdata[8], 0);
  endtask

  task automatic tEdges();
    int p;
    wr(RUN | M_RISE); settle(p);
    rawStep("R5 rise mode rising", 1'b1, 1);
    rawStep("R5 rise mode falling", 1'b0, 0);
    wr(RUN | M_FALL); settle(p);
    rawStep("R5 fall mode rising", 1'b1, 0);
    rawStep("R5 fall mode falling", 1'b0, 1);
    wr(RUN | M_BOTH); settle(p);
    rawStep("R5 both mode rising", 1'b1, 1);
    rawStep("R5 both mode falling", 1'b0, 1);
    wr(RUN | M_OFF); settle(p);
    rawStep("R4 off rising", 1'b1, 0);
    rawStep("R4 off falling", 1'b0, 0);
  endtask

  task automatic tInvert();
    int p;
    wr(RUN | INV | M_RISE); settle(p);
    chk("R6 inverted status", regRdata[8], 1);
    rawStep("R6 rise mode raw rising", 1'b1, 0);
    rawStep("R6 rise mode raw falling", 1'b0, 1);
  endtask

  task automatic tDisable();
    int p;
    wr(RUN | M_BOTH | 32'h12); settle(p);
    rawStep("R7 setup rise", 1'b1, 1);
    wr(M_BOTH | 32'h12); settle(p);
    chk("R10 disable keeps fields", regRdata, 32'h0000_00D2);
    chk("R3 disabled status", regRdata[8], 0);
    rawStep("R7 off falling", 1'b0, 0);
    rawStep("R7 off rising", 1'b1, 0);
    wr(RUN | M_BOTH | 32'h12); settle(p);
    chk("R7 no pulse on re-enable", p, 0);
    chk("R10 enable keeps fields", regRdata, 32'h0000_81D2);
    rawStep("R7 back low", 1'b0, 1);
  endtask

  task automatic tPin();
    int p;
    @(negedge clk); cmpRaw = 1'b1;
    wr(RUN | DRV | M_OFF); settle(p);
    chk("R8 pinOe on", pinOe, 1);
    chk("R8 pinOut high", pinOut, 1);
    wr(RUN | M_OFF); settle(p);
    chk("R8 pinOe off", pinOe, 0);
    chk("R8 pinOut quiet", pinOut, 0);
    wr(DRV | M_OFF); settle(p);
    chk("R8 pinOut while disabled", pinOut, 0);
    @(negedge clk); cmpRaw = 1'b0;
  endtask

  task automatic tMux();
    int p;
    wr(32'h11); settle(p);
    chk("R9 posSel internal", posSel, 1);
    chk("R9 negSel second", negSel, 2'b01);
    wr(32'h02); settle(p);
    chk("R9 posSel pin", posSel, 0);
    chk("R9 negSel third", negSel, 2'b10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tReset();
    @(negedge clk); rstN = 1'b1;
    tRegAccess();
    tStatus();
    tEdges();
    tInvert();
    @(negedge clk); cmpRaw = 1'b0;
    tDisable();
    tPin();
    tMux();
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule